// File: doc/BRIEF.md
# Linked-List Descriptor DMA Engine

The engine moves data between system memory and a card-side data port without processor help for each word. Software builds a list of four-word descriptors in memory, each naming a buffer and its length, marks every descriptor as owned by the engine, programs the address of the first descriptor and sets the enable bit. The engine fetches each descriptor, checks the ownership bit, streams the buffer word by word between memory and the card port, then writes the first word back with the ownership bit cleared so software can reuse the slot.

Descriptors link either through an explicit pointer in their fourth word or by sitting back to back 16 bytes apart, with an end-of-ring flag that returns the walk to the base address. A descriptor found still owned by software parks the engine in a suspend state until software writes the resume register. Completion, bus errors, card errors, missing descriptors and host aborts set sticky write-one-to-clear status bits, which are folded into two summary bits and one interrupt line. The current sequencer state is visible as a 4-bit code both on its own port and inside the status word.

Top module: `dma_desc_engine`

## Requirements
- R1: After reset the status word reads 0, the state code is 0 (idle) and the interrupt is low.
- R2: A descriptor is fetched as four 32-bit words at its address, offsets 0, 4, 8 and 12: configuration, byte count, buffer address, next-descriptor address. With control bit 4 at 0 the buffer is read from memory in ascending word order and each word is presented on the card transmit port, held until the card accepts it.
- R3: With control bit 4 at 1 each word taken from the card receive port is written to the buffer in ascending word order.
- R4: A fetched descriptor whose configuration bit 31 (ownership) is 0 sets status bit 4 and moves the engine to the suspend state (code 1) without touching the buffer; a write to register select 3 while suspended fetches the same descriptor again.
- R5: When a buffer is finished the engine rewrites the configuration word with bit 31 cleared, and sets status bit 0 (transmit) or bit 1 (receive) unless configuration bit 1 (interrupt suppress) is set.
- R6: After closing a descriptor with configuration bit 2 (last) the engine returns to idle; otherwise it fetches the next descriptor.
- R7: With configuration bit 4 (chain) set the next descriptor address is the fourth descriptor word; without it the next address is the current one plus 16, or the base address when configuration bit 5 (end of ring) is set.
- R8: A byte-count field of zero, where the field is the low SIZE_W bits of word 1, means 2^SIZE_W bytes.
- R9: Status bits are cleared by writing 1 to them at register select 1; bit 8 is the OR of bits 0 and 1, bit 9 the OR of bits 2, 4, 5 and 10, and the interrupt is the OR of bits 8 and 9.
- R10: A memory response with the error flag set sets status bit 2 and returns the engine to idle without closing the descriptor.
- R11: If the card error input is high while a buffer is moving, the written-back configuration word has bit 30 set and status bit 5 is set.
- R12: Register select 0 is control: writing bit 7 as 1 while idle starts a walk at the base address held in register select 2; writing bit 7 as 0 while not idle aborts to idle and sets status bit 10; writing bit 0 as 1 returns to idle and clears every status bit.
- R13: The state code uses 0 idle, 1 suspend, 2 descriptor fetch, 3 descriptor check, 4 waiting for the card to take a word read from memory, 5 waiting for a word from the card, 6 memory read, 7 memory write, 8 descriptor close, and appears on state_o and in status bits 16 to 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 control, 1 status, 2 base address, 3 resume |
| reg_wdata_i | input | 32 | Register write data |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ready_i | input | 1 | Memory completes the request this cycle |
| mem_err_i | input | 1 | Memory response carries an error |
| mem_rdata_i | input | 32 | Memory read data, valid with mem_ready_i |
| card_tx_valid_o | output | 1 | Word available for the card |
| card_tx_data_o | output | 32 | Word for the card |
| card_tx_ready_i | input | 1 | Card accepts the word |
| card_rx_valid_i | input | 1 | Card offers a word |
| card_rx_data_i | input | 32 | Word from the card |
| card_rx_ready_o | output | 1 | Engine accepts the card word |
| card_err_i | input | 1 | Card reports an error on the current buffer |
| status_o | output | 32 | Status word including the state code |
| state_o | output | 4 | Current state code |
| irq_o | output | 1 | Interrupt |

## Verification
The bench targets the address walk: a chained pair, a back-to-back pair, and an end-of-ring descriptor whose wrap lands on its own already-returned slot while a valid trap descriptor waits 16 bytes further on, so an engine that ignores the ring flag finishes idle instead of suspending. It checks the ownership handoff both ways, showing a design that skips the check streams stale data and one that forgets the write-back leaves bit 31 set. A zero byte count must yield exactly 2^SIZE_W bytes, not zero words. Bus errors, card errors, aborts mid-stall and soft reset are each checked for the exact status word, so a summary bit wired to the wrong sources shows up as a wrong value.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_SUSP   = 4'd1,
    ST_DFETCH = 4'd2,
    ST_DCHECK = 4'd3,
    ST_TXWAIT = 4'd4,
    ST_RXWAIT = 4'd5,
    ST_MRD    = 4'd6,
    ST_MWR    = 4'd7,
    ST_CLOSE  = 4'd8
  } dstate_e;

  // descriptor configuration word
  localparam int CFG_NOIRQ = 1;
  localparam int CFG_LAST  = 2;
  localparam int CFG_FIRST = 3;
  localparam int CFG_CHAIN = 4;
  localparam int CFG_RING  = 5;
  localparam int CFG_CERR  = 30;
  localparam int CFG_OWN   = 31;

  // control register
  localparam int CTL_SRST = 0;
  localparam int CTL_DIR  = 4;
  localparam int CTL_EN   = 7;

  // status register
  localparam int STS_TX    = 0;
  localparam int STS_RX    = 1;
  localparam int STS_BERR  = 2;
  localparam int STS_NODSC = 4;
  localparam int STS_CERR  = 5;
  localparam int STS_NSUM  = 8;
  localparam int STS_ASUM  = 9;
  localparam int STS_ABRT  = 10;
  localparam int STS_STLSB = 13;

  // register selects
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_BASE = 2'd2;
  localparam logic [1:0] SEL_POLL = 2'd3;

  typedef struct packed {
    logic tx;
    logic rx;
    logic berr;
    logic nodsc;
    logic cerr;
  } dma_evt_t;

endpackage

// File: rtl/dma_desc_regs.sv
module dma_desc_regs
  import dma_desc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [31:0]   reg_wdata_i,
  input  dma_evt_t      evt_i,
  input  dstate_e       state_i,
  output logic [AW-1:0] base_o,
  output logic          dir_o,
  output logic          start_o,
  output logic          resume_o,
  output logic          abort_o,
  output logic          srst_o,
  output logic [31:0]   status_o,
  output logic          irq_o
);

  typedef struct packed {
    logic tx;
    logic rx;
    logic berr;
    logic nodsc;
    logic cerr;
    logic abrt;
  } sticky_t;

  sticky_t       sticky_q, sticky_d, set_w, clr_w;
  logic [AW-1:0] base_q;
  logic          dir_q;
  logic          wr_ctrl, busy;
  logic          nsum, asum;

  assign busy     = (state_i != ST_IDLE);
  assign wr_ctrl  = reg_we_i && (reg_sel_i == SEL_CTRL);
  assign srst_o   = wr_ctrl && reg_wdata_i[CTL_SRST];
  assign start_o  = wr_ctrl && !srst_o && reg_wdata_i[CTL_EN] && !busy;
  assign abort_o  = wr_ctrl && !srst_o && !reg_wdata_i[CTL_EN] && busy;
  assign resume_o = reg_we_i && (reg_sel_i == SEL_POLL);

  always_comb begin
    set_w       = '0;
    set_w.tx    = evt_i.tx;
    set_w.rx    = evt_i.rx;
    set_w.berr  = evt_i.berr;
    set_w.nodsc = evt_i.nodsc;
    set_w.cerr  = evt_i.cerr;
    set_w.abrt  = abort_o;
    clr_w       = '0;
    if (reg_we_i && reg_sel_i == SEL_STAT) begin
      clr_w.tx    = reg_wdata_i[STS_TX];
      clr_w.rx    = reg_wdata_i[STS_RX];
      clr_w.berr  = reg_wdata_i[STS_BERR];
      clr_w.nodsc = reg_wdata_i[STS_NODSC];
      clr_w.cerr  = reg_wdata_i[STS_CERR];
      clr_w.abrt  = reg_wdata_i[STS_ABRT];
    end
    // a new event wins over a clear in the same cycle
    sticky_d = (sticky_q & ~clr_w) | set_w;
    if (srst_o) sticky_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_q <= '0;
      base_q   <= '0;
      dir_q    <= 1'b0;
    end else begin
      sticky_q <= sticky_d;
      if (reg_we_i && reg_sel_i == SEL_BASE) base_q <= reg_wdata_i[AW-1:0];
      if (start_o) dir_q <= reg_wdata_i[CTL_DIR];
    end
  end

  assign nsum = sticky_q.tx | sticky_q.rx;
  assign asum = sticky_q.berr | sticky_q.nodsc | sticky_q.cerr | sticky_q.abrt;

  always_comb begin
    status_o                          = '0;
    status_o[STS_TX]                  = sticky_q.tx;
    status_o[STS_RX]                  = sticky_q.rx;
    status_o[STS_BERR]                = sticky_q.berr;
    status_o[STS_NODSC]               = sticky_q.nodsc;
    status_o[STS_CERR]                = sticky_q.cerr;
    status_o[STS_NSUM]                = nsum;
    status_o[STS_ASUM]                = asum;
    status_o[STS_ABRT]                = sticky_q.abrt;
    status_o[STS_STLSB+3:STS_STLSB]   = state_i;
  end

  assign irq_o  = nsum | asum;
  assign base_o = base_q;
  assign dir_o  = dir_q;

  assert_srst_clears_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o |=> (sticky_q == '0));

  assert_nodsc_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.nodsc && !srst_o) |=> sticky_q.nodsc);

  assert_irq_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past((evt_i != '0) || abort_o));

endmodule

// File: rtl/dma_desc_fsm.sv
module dma_desc_fsm
  import dma_desc_pkg::*;
#(
  parameter int AW     = 32,
  parameter int SIZE_W = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] base_i,
  input  logic          dir_i,
  input  logic          start_i,
  input  logic          resume_i,
  input  logic          abort_i,
  input  logic          srst_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic          mem_err_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          card_tx_valid_o,
  output logic [31:0]   card_tx_data_o,
  input  logic          card_tx_ready_i,
  input  logic          card_rx_valid_i,
  input  logic [31:0]   card_rx_data_i,
  output logic          card_rx_ready_o,
  input  logic          card_err_i,
  output dma_evt_t      evt_o,
  output dstate_e       state_o
);

  localparam int RW = SIZE_W + 1;
  localparam logic [RW-1:0] MAX_BYTES = RW'(1) << SIZE_W;
  localparam logic [AW-1:0] DSC_STEP  = AW'(16);

  dstate_e       state_q, state_d;
  logic [AW-1:0] cur_q, cur_d;
  logic [1:0]    idx_q, idx_d;
  logic [31:0]   cfg_q, cfg_d;
  logic [SIZE_W-1:0] size_q, size_d;
  logic [31:0]   buf_q, buf_d;
  logic [31:0]   nxt_q, nxt_d;
  logic [RW-1:0] rem_q, rem_d;
  logic [31:0]   data_q, data_d;
  logic          cerr_q, cerr_d;
  logic          last_word;
  logic [AW-1:0] next_dsc;
  logic [31:0]   close_word;
  logic          unused_cfg;

  assign unused_cfg = ^{cfg_q[29:6], cfg_q[CFG_FIRST], cfg_q[0]};

  assign last_word = (rem_q <= RW'(4));

  always_comb begin
    if (cfg_q[CFG_CHAIN])     next_dsc = AW'(nxt_q);
    else if (cfg_q[CFG_RING]) next_dsc = base_i;
    else                      next_dsc = cur_q + DSC_STEP;
  end

  always_comb begin
    close_word           = cfg_q;
    close_word[CFG_OWN]  = 1'b0;
    close_word[CFG_CERR] = cfg_q[CFG_CERR] | cerr_q;
  end

  // memory and card port decode
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = AW'(buf_q);
    mem_wdata_o = data_q;
    unique case (state_q)
      ST_DFETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q + AW'({idx_q, 2'b00});
      end
      ST_MRD: mem_req_o = 1'b1;
      ST_MWR: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
      end
      ST_CLOSE: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_q;
        mem_wdata_o = close_word;
      end
      default: ;
    endcase
  end

  assign card_tx_valid_o = (state_q == ST_TXWAIT);
  assign card_tx_data_o  = data_q;
  assign card_rx_ready_o = (state_q == ST_RXWAIT);

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    idx_d   = idx_q;
    cfg_d   = cfg_q;
    size_d  = size_q;
    buf_d   = buf_q;
    nxt_d   = nxt_q;
    rem_d   = rem_q;
    data_d  = data_q;
    cerr_d  = cerr_q;
    evt_o   = '0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        cur_d   = base_i;
        idx_d   = '0;
        state_d = ST_DFETCH;
      end
      ST_SUSP: if (resume_i) begin
        idx_d   = '0;
        state_d = ST_DFETCH;
      end
      ST_DFETCH: if (mem_ready_i) begin
        if (mem_err_i) begin
          evt_o.berr = 1'b1;
          state_d    = ST_IDLE;
        end else begin
          unique case (idx_q)
            2'd0:    cfg_d  = mem_rdata_i;
            2'd1:    size_d = mem_rdata_i[SIZE_W-1:0];
            2'd2:    buf_d  = mem_rdata_i;
            default: nxt_d  = mem_rdata_i;
          endcase
          idx_d = idx_q + 2'd1;
          if (idx_q == 2'd3) state_d = ST_DCHECK;
        end
      end
      ST_DCHECK: begin
        if (!cfg_q[CFG_OWN]) begin
          evt_o.nodsc = 1'b1;
          state_d     = ST_SUSP;
        end else begin
          rem_d   = (size_q == '0) ? MAX_BYTES : {1'b0, size_q};
          cerr_d  = 1'b0;
          state_d = dir_i ? ST_RXWAIT : ST_MRD;
        end
      end
      ST_MRD: begin
        cerr_d = cerr_q | card_err_i;
        if (mem_ready_i) begin
          if (mem_err_i) begin
            evt_o.berr = 1'b1;
            state_d    = ST_IDLE;
          end else begin
            data_d  = mem_rdata_i;
            state_d = ST_TXWAIT;
          end
        end
      end
      ST_TXWAIT: begin
        cerr_d = cerr_q | card_err_i;
        if (card_tx_ready_i) begin
          buf_d   = buf_q + 32'd4;
          rem_d   = rem_q - RW'(4);
          state_d = last_word ? ST_CLOSE : ST_MRD;
        end
      end
      ST_RXWAIT: begin
        cerr_d = cerr_q | card_err_i;
        if (card_rx_valid_i) begin
          data_d  = card_rx_data_i;
          state_d = ST_MWR;
        end
      end
      ST_MWR: begin
        cerr_d = cerr_q | card_err_i;
        if (mem_ready_i) begin
          if (mem_err_i) begin
            evt_o.berr = 1'b1;
            state_d    = ST_IDLE;
          end else begin
            buf_d   = buf_q + 32'd4;
            rem_d   = rem_q - RW'(4);
            state_d = last_word ? ST_CLOSE : ST_RXWAIT;
          end
        end
      end
      ST_CLOSE: if (mem_ready_i) begin
        if (mem_err_i) begin
          evt_o.berr = 1'b1;
          state_d    = ST_IDLE;
        end else begin
          if (!cfg_q[CFG_NOIRQ]) begin
            evt_o.rx = dir_i;
            evt_o.tx = !dir_i;
          end
          evt_o.cerr = cerr_q;
          if (cfg_q[CFG_LAST]) begin
            state_d = ST_IDLE;
          end else begin
            cur_d   = next_dsc;
            idx_d   = '0;
            state_d = ST_DFETCH;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (srst_i || abort_i) begin
      state_d = ST_IDLE;
      evt_o   = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      idx_q   <= '0;
      cfg_q   <= '0;
      size_q  <= '0;
      buf_q   <= '0;
      nxt_q   <= '0;
      rem_q   <= '0;
      data_q  <= '0;
      cerr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      idx_q   <= idx_d;
      cfg_q   <= cfg_d;
      size_q  <= size_d;
      buf_q   <= buf_d;
      nxt_q   <= nxt_d;
      rem_q   <= rem_d;
      data_q  <= data_d;
      cerr_q  <= cerr_d;
    end
  end

  assign state_o = state_q;

  assert_close_drops_own_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CLOSE) |-> (mem_req_o && mem_we_o && !mem_wdata_o[CFG_OWN]));

  assert_suspend_after_check_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_SUSP) |-> ($past(state_q) == ST_DCHECK));

  assert_tx_word_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_tx_valid_o && !card_tx_ready_i && !srst_i && !abort_i)
      |=> (card_tx_valid_o && $stable(card_tx_data_o)));

  assert_chain_target_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DFETCH && idx_q == 2'd0 && $past(state_q) == ST_CLOSE
      && $past(cfg_q[CFG_CHAIN])) |-> (mem_addr_o == AW'($past(nxt_q))));

endmodule

// File: rtl/dma_desc_engine.sv
module dma_desc_engine
  import dma_desc_pkg::*;
#(
  parameter int AW     = 32,
  parameter int SIZE_W = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [31:0]   reg_wdata_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic          mem_err_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          card_tx_valid_o,
  output logic [31:0]   card_tx_data_o,
  input  logic          card_tx_ready_i,
  input  logic          card_rx_valid_i,
  input  logic [31:0]   card_rx_data_i,
  output logic          card_rx_ready_o,
  input  logic          card_err_i,
  output logic [31:0]   status_o,
  output logic [3:0]    state_o,
  output logic          irq_o
);

  dma_evt_t      evt;
  dstate_e       state;
  logic [AW-1:0] base;
  logic          dir, start, resume, abort, srst;

  dma_desc_regs #(.AW(AW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_sel_i   (reg_sel_i),
    .reg_wdata_i (reg_wdata_i),
    .evt_i       (evt),
    .state_i     (state),
    .base_o      (base),
    .dir_o       (dir),
    .start_o     (start),
    .resume_o    (resume),
    .abort_o     (abort),
    .srst_o      (srst),
    .status_o    (status_o),
    .irq_o       (irq_o)
  );

  dma_desc_fsm #(.AW(AW), .SIZE_W(SIZE_W)) u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .base_i          (base),
    .dir_i           (dir),
    .start_i         (start),
    .resume_i        (resume),
    .abort_i         (abort),
    .srst_i          (srst),
    .mem_req_o       (mem_req_o),
    .mem_we_o        (mem_we_o),
    .mem_addr_o      (mem_addr_o),
    .mem_wdata_o     (mem_wdata_o),
    .mem_ready_i     (mem_ready_i),
    .mem_err_i       (mem_err_i),
    .mem_rdata_i     (mem_rdata_i),
    .card_tx_valid_o (card_tx_valid_o),
    .card_tx_data_o  (card_tx_data_o),
    .card_tx_ready_i (card_tx_ready_i),
    .card_rx_valid_i (card_rx_valid_i),
    .card_rx_data_i  (card_rx_data_i),
    .card_rx_ready_o (card_rx_ready_o),
    .card_err_i      (card_err_i),
    .evt_o           (evt),
    .state_o         (state)
  );

  assign state_o = state;

endmodule

// File: tb/dma_desc_engine_test.sv
module dma_desc_engine_test;

  localparam int SW = 6;
  localparam logic [31:0] OWN = 32'h8000_0000, LAST = 32'h4, FIRST = 32'h8,
                          CHAIN = 32'h10, RING = 32'h20, NOIRQ = 32'h2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        mem_req, mem_we, mem_ready, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_ready, rx_valid, rx_ready;
  logic [31:0] tx_data, rx_data;
  logic        card_err = 1'b0;
  logic [31:0] status;
  logic [3:0]  state;
  logic        irq;

  logic [31:0] mem [0:255];
  logic [31:0] tx_log [0:127];
  int          tx_cnt = 0;
  logic [31:0] rx_word = 32'hA000;
  logic [2:0]  tick = '0;
  logic        tx_allow = 1'b1;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  dma_desc_engine #(.AW(32), .SIZE_W(SW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready), .mem_err_i(mem_err),
    .mem_rdata_i(mem_rdata),
    .card_tx_valid_o(tx_valid), .card_tx_data_o(tx_data), .card_tx_ready_i(tx_ready),
    .card_rx_valid_i(rx_valid), .card_rx_data_i(rx_data), .card_rx_ready_o(rx_ready),
    .card_err_i(card_err), .status_o(status), .state_o(state), .irq_o(irq)
  );

  // memory and card models
  assign mem_rdata = mem[mem_addr[9:2]];
  assign mem_ready = (tick != 3'd2);
  assign mem_err   = mem_req && err_en && (mem_addr == err_addr);
  assign tx_ready  = tx_allow && !tick[0];
  assign rx_valid  = (tick != 3'd5);
  assign rx_data   = rx_word;

  always @(posedge clk) begin
    tick <= tick + 3'd1;
    if (mem_req && mem_we && mem_ready && !mem_err) mem[mem_addr[9:2]] <= mem_wdata;
    if (tx_valid && tx_ready) begin
      tx_log[tx_cnt[6:0]] <= tx_data;
      tx_cnt <= tx_cnt + 1;
    end
    if (rx_valid && rx_ready) rx_word <= rx_word + 32'd1;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic settle(input string req);
    int n = 0;
    repeat (3) @(negedge clk);
    while (!(state == 4'd0 || state == 4'd1) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) begin
      checks++; errors++;
      $display("FAIL %s engine never settled: actual state %h expected 0 or 1", req, state);
    end
  endtask

  task automatic put_dsc(input int a, input logic [31:0] cfg, input logic [31:0] sz,
                         input logic [31:0] bufa, input logic [31:0] nxt);
    mem[a/4] = cfg; mem[a/4+1] = sz; mem[a/4+2] = bufa; mem[a/4+3] = nxt;
  endtask

  task automatic clear_status();
    reg_wr(2'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    chk("R1", "status", status, 32'h0);
    chk("R1", "state", {28'h0, state}, 32'h0);
    chk("R1", "irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_tx_chain();
    int t0 = tx_cnt;
    put_dsc(32'h000, OWN | CHAIN | FIRST, 32'd8, 32'h200, 32'h040);
    put_dsc(32'h040, OWN | CHAIN | LAST, 32'd12, 32'h300, 32'h0);
    reg_wr(2'd2, 32'h000);
    reg_wr(2'd0, 32'h80);
    settle("R2");
    chk("R2", "tx words", tx_cnt - t0, 5);
    chk("R2", "tx word0", tx_log[t0],   mem[32'h200/4]);
    chk("R2", "tx word1", tx_log[t0+1], mem[32'h204/4]);
    chk("R7", "chain word0", tx_log[t0+2], mem[32'h300/4]);
    chk("R7", "chain word2", tx_log[t0+4], mem[32'h308/4]);
    chk("R5", "own dropped d0", mem[0], CHAIN | FIRST);
    chk("R5", "own dropped d1", mem[32'h40/4], CHAIN | LAST);
    chk("R6", "idle after last", {28'h0, state}, 32'h0);
    chk("R9", "status tx", status, 32'h101);
    chk("R9", "irq", {31'h0, irq}, 32'h1);
    clear_status();
  endtask

  task automatic t_rx_ring();
    logic [31:0] w0 = rx_word;
    put_dsc(32'h080, OWN | FIRST, 32'd8, 32'h280, 32'h0);
    put_dsc(32'h090, OWN | LAST, 32'd4, 32'h2C0, 32'h0);
    reg_wr(2'd2, 32'h080);
    reg_wr(2'd0, 32'h90);
    settle("R3");
    chk("R3", "rx word0", mem[32'h280/4], w0);
    chk("R3", "rx word1", mem[32'h284/4], w0 + 1);
    chk("R7", "step 16 word", mem[32'h2C0/4], w0 + 2);
    chk("R5", "rx status", status, 32'h102);
    clear_status();
  endtask

  task automatic t_noirq();
    int t0 = tx_cnt;
    put_dsc(32'h0C0, OWN | LAST | NOIRQ, 32'd4, 32'h200, 32'h0);
    reg_wr(2'd2, 32'h0C0);
    reg_wr(2'd0, 32'h80);
    settle("R5");
    chk("R5", "suppressed status", status, 32'h0);
    chk("R5", "suppressed irq", {31'h0, irq}, 32'h0);
    chk("R5", "own dropped", mem[32'h0C0/4], LAST | NOIRQ);
    chk("R5", "tx words", tx_cnt - t0, 1);
  endtask

  task automatic t_not_owned();
    int t0 = tx_cnt;
    put_dsc(32'h100, LAST, 32'd4, 32'h200, 32'h0);
    reg_wr(2'd2, 32'h100);
    reg_wr(2'd0, 32'h80);
    settle("R4");
    chk("R4", "state suspend", {28'h0, state}, 32'h1);
    chk("R13", "status with state", status, 32'h2210);
    chk("R4", "no data moved", tx_cnt - t0, 0);
    clear_status();
    mem[32'h100/4] = OWN | LAST;
    reg_wr(2'd3, 32'h0);
    settle("R4");
    chk("R4", "resumed idle", {28'h0, state}, 32'h0);
    chk("R4", "resumed status", status, 32'h101);
    chk("R4", "resumed tx", tx_cnt - t0, 1);
    clear_status();
  endtask

  task automatic t_size_zero();
    int t0 = tx_cnt;
    put_dsc(32'h140, OWN | LAST, 32'd0, 32'h200, 32'h0);
    reg_wr(2'd2, 32'h140);
    reg_wr(2'd0, 32'h80);
    settle("R8");
    chk("R8", "max words", tx_cnt - t0, (1 << SW) / 4);
    chk("R8", "last word", tx_log[t0 + (1 << SW) / 4 - 1], mem[(32'h200 + (1 << SW) - 4) / 4]);
    clear_status();
  endtask

  task automatic t_ring_wrap();
    int t0 = tx_cnt;
    put_dsc(32'h180, OWN | RING, 32'd4, 32'h204, 32'h0);
    put_dsc(32'h190, OWN | LAST, 32'd4, 32'h208, 32'h0);
    reg_wr(2'd2, 32'h180);
    reg_wr(2'd0, 32'h80);
    settle("R7");
    chk("R7", "wrap to base suspends", {28'h0, state}, 32'h1);
    chk("R7", "wrap status", status, 32'h2311);
    chk("R7", "trap untouched", mem[32'h190/4], OWN | LAST);
    chk("R7", "one word", tx_cnt - t0, 1);
    reg_wr(2'd0, 32'h1);
    chk("R12", "soft reset status", status, 32'h0);
    chk("R12", "soft reset state", {28'h0, state}, 32'h0);
  endtask

  task automatic t_bus_err();
    int t0 = tx_cnt;
    put_dsc(32'h1C0, OWN | LAST, 32'd8, 32'h200, 32'h0);
    err_addr = 32'h204; err_en = 1'b1;
    reg_wr(2'd2, 32'h1C0);
    reg_wr(2'd0, 32'h80);
    settle("R10");
    err_en = 1'b0;
    chk("R10", "bus error status", status, 32'h204);
    chk("R10", "not closed", mem[32'h1C0/4], OWN | LAST);
    chk("R10", "words before error", tx_cnt - t0, 1);
    clear_status();
  endtask

  task automatic t_card_err();
    logic [31:0] w0 = rx_word;
    put_dsc(32'h1E0, OWN | LAST, 32'd4, 32'h2E0, 32'h0);
    reg_wr(2'd2, 32'h1E0);
    card_err = 1'b1;
    reg_wr(2'd0, 32'h90);
    settle("R11");
    card_err = 1'b0;
    chk("R11", "rx data", mem[32'h2E0/4], w0);
    chk("R11", "written back config", mem[32'h1E0/4], 32'h4000_0000 | LAST);
    chk("R11", "card error status", status, 32'h322);
    reg_wr(2'd1, 32'h20);
    chk("R9", "partial clear", status, 32'h102);
    clear_status();
  endtask

  task automatic t_abort();
    put_dsc(32'h000, OWN | LAST, 32'd8, 32'h200, 32'h0);
    tx_allow = 1'b0;
    reg_wr(2'd2, 32'h000);
    reg_wr(2'd0, 32'h80);
    repeat (20) @(negedge clk);
    chk("R13", "waiting on card", {28'h0, state}, 32'h4);
    chk("R13", "state in status", {19'h0, status[16:13]}, 32'h4);
    reg_wr(2'd0, 32'h0);
    chk("R12", "abort state", {28'h0, state}, 32'h0);
    chk("R12", "abort status", status, 32'h600);
    tx_allow = 1'b1;
    clear_status();
    chk("R9", "all cleared", status, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h1000 + i * 32'h11;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_chain();
    t_rx_ring();
    t_noirq();
    t_not_owned();
    t_size_zero();
    t_ring_wrap();
    t_bus_err();
    t_card_err();
    t_abort();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual state %h expected completion", state);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule